// File: doc/BRIEF.md
# System control register block with prescaled event counter

This block is a small memory-mapped peripheral on a single-cycle 32-bit register port. Each cycle it takes an address, a write enable and write data, and it returns read data combinationally for the addressed word. It holds a two-bit lamp register that drives two output pins and a free 32-bit control word. It also has a button word that always reads as zero, because no buttons are attached.

The block has three timekeeping functions, and all of them run from the system clock. Two seconds-style counters count upward, one once per second and one a hundred times per second. Their rates come from divide counters whose terminal counts are derived from the clock-frequency parameter. A down-counting prescaler is stepped by a one-cycle tick enable, and that tick is a fixed fraction of the system clock. Each time the prescaler wraps, it reloads from a software-set reload value and advances a 32-bit event counter. Software can write every counter directly.

The byte offsets are fixed: lamp 0x00, button 0x08, seconds 0x10, centiseconds 0x14, event count 0x18, reload 0x1C, live prescaler 0x20, control 0x4C. No other address, including an unaligned one, is mapped.

Top module: `sysctl_regs`

## Requirements
- R1: While reset is low, every register reads as zero: lamp, control, reload, live prescaler, event count and both seconds counters.
- R2: A write to offset 0x00 stores only bits [1:0]. They appear on `led` from the next cycle, and a read of 0x00 returns them with bits [31:2] at zero.
- R3: Offset 0x4C reads back all 32 bits of the last value written to it.
- R4: Offset 0x08 and every unmapped or unaligned address read as zero. A write to such an address changes no register.
- R5: A prescale tick lasts one cycle and occurs every CLK_HZ/PS_HZ cycles. On a tick, a non-zero live prescaler (0x20) decreases by one. Between ticks it holds its value.
- R6: On a tick that finds the live prescaler at zero, the prescaler reloads from 0x1C and the event count (0x18) rises by one. For example, with reload 5 and a start of 7, the sequence is 7,6,5,4,3,2,1,0,5,4.
- R7: With a reload value of zero, the live prescaler stays at zero and the event count rises on every tick.
- R8: A write to 0x1C leaves the live prescaler unchanged. A reload on the same cycle as that write uses the previous reload value.
- R9: A write to 0x18 or 0x20 on the same cycle as a tick takes precedence over that tick's update of the written register. The other register still takes its tick update.
- R10: The seconds counter (0x10) rises by one every CLK_HZ cycles, and the centiseconds counter (0x14) rises by one every CLK_HZ/100 cycles. Both start from zero at reset.
- R11: A write to 0x10 or 0x14 loads that counter and restarts its period. The next increment comes one full period after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the accessed word |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr`, combinational |
| led | output | 2 | Lamp register bits |

## Verification
Two things can land on the same cycle: a software write to the event count, the live prescaler or the reload value, and a prescale tick that decrements or reloads. The same is true of a seconds-counter write and that counter's own divider terminal count. The bench sweeps the write across every phase of the tick period, starting with the prescaler at zero and at one. In this way the write lands before, on and after the reload. A behavioural model is stepped on every edge and defines the outcome: the write wins, the other register takes its tick update, and a same-cycle reload uses the old reload value. The read data is compared against this model on every cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    // Byte offsets of the register words
    localparam int OFF_LAMP   = 'h00;
    localparam int OFF_KEYS   = 'h08;
    localparam int OFF_SEC    = 'h10;
    localparam int OFF_CENTI  = 'h14;
    localparam int OFF_EVENTS = 'h18;
    localparam int OFF_RELOAD = 'h1C;
    localparam int OFF_PRESC  = 'h20;
    localparam int OFF_CTRL   = 'h4C;

    localparam int LAMP_W = 2;

    // True for an offset that holds state
    function automatic logic holds_state(input int unsigned a);
        return (a == OFF_LAMP)   || (a == OFF_SEC)    || (a == OFF_CENTI) ||
               (a == OFF_EVENTS) || (a == OFF_RELOAD) || (a == OFF_PRESC) ||
               (a == OFF_CTRL);
    endfunction

endpackage

// File: rtl/sc_divider.sv
// Free-running divide-by-DIV counter; tick is high on its last count.
module sc_divider #(
    parameter int unsigned DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_st_t;

    div_st_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        tick  = (div_q.cnt == LAST);
        if (restart || tick) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/sc_rate_counter.sv
// Up counter advanced once per DIV cycles; a load restarts the period.
module sc_rate_counter #(
    parameter int unsigned DIV = 100,
    parameter int unsigned W   = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value
);
    typedef struct packed {
        logic [W-1:0] val;
    } rc_st_t;

    rc_st_t rc_d, rc_q;
    logic   period_tick;

    sc_divider #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .tick    (period_tick)
    );

    always_comb begin
        rc_d = rc_q;
        if (load) begin
            rc_d.val = load_val;
        end else if (period_tick) begin
            rc_d.val = rc_q.val + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_q <= '0;
        end else begin
            rc_q <= rc_d;
        end
    end

    assign value = rc_q.val;
endmodule

// File: rtl/sc_prescaler.sv
// Reloading down counter plus the event counter it advances on each wrap.
module sc_prescaler #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         set_reload,
    input  logic         set_live,
    input  logic         set_count,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] reload,
    output logic [W-1:0] live,
    output logic [W-1:0] count
);
    typedef struct packed {
        logic [W-1:0] reload;
        logic [W-1:0] live;
        logic [W-1:0] count;
    } ps_st_t;

    ps_st_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (tick) begin
            if (ps_q.live == '0) begin
                // wrap: reload (old reload value) and count one event
                ps_d.live  = ps_q.reload;
                ps_d.count = ps_q.count + W'(1);
            end else begin
                ps_d.live  = ps_q.live - W'(1);
            end
        end
        // software writes win over the tick update of the same register
        if (set_reload) ps_d.reload = wdata;
        if (set_live)   ps_d.live   = wdata;
        if (set_count)  ps_d.count  = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign reload = ps_q.reload;
    assign live   = ps_q.live;
    assign count  = ps_q.count;
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
    parameter int unsigned CLK_HZ = 100_000_000,
    parameter int unsigned PS_HZ  = 20_000_000,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        led
);
    import sysctl_pkg::*;

    localparam int unsigned PS_DIV    = CLK_HZ / PS_HZ;
    localparam int unsigned SEC_DIV   = CLK_HZ;
    localparam int unsigned CENTI_DIV = CLK_HZ / 100;
    localparam int unsigned N_RATE    = 2;

    typedef struct packed {
        logic [LAMP_W-1:0] lamp;
        logic [DATA_W-1:0] ctrl;
    } top_st_t;

    top_st_t top_d, top_q;

    logic              ps_tick;
    logic [DATA_W-1:0] reload, live, count;
    logic [DATA_W-1:0] rate_val [N_RATE];

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
        return a == ADDR_W'(off);
    endfunction

    // prescale tick enable
    sc_divider #(.DIV(PS_DIV)) u_ps_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (1'b0),
        .tick    (ps_tick)
    );

    sc_prescaler #(.W(DATA_W)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (ps_tick),
        .set_reload (wr_en && hit(addr, OFF_RELOAD)),
        .set_live   (wr_en && hit(addr, OFF_PRESC)),
        .set_count  (wr_en && hit(addr, OFF_EVENTS)),
        .wdata      (wr_data),
        .reload     (reload),
        .live       (live),
        .count      (count)
    );

    // index 0: once-per-second counter, index 1: hundred-per-second counter
    for (genvar g = 0; g < N_RATE; g++) begin : g_rate
        localparam int unsigned DIV = (g == 0) ? SEC_DIV : CENTI_DIV;
        localparam int          OFF = (g == 0) ? OFF_SEC : OFF_CENTI;
        sc_rate_counter #(.DIV(DIV), .W(DATA_W)) u_rate (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (wr_en && hit(addr, OFF)),
            .load_val (wr_data),
            .value    (rate_val[g])
        );
    end

    always_comb begin
        top_d = top_q;
        if (wr_en && hit(addr, OFF_LAMP)) top_d.lamp = wr_data[LAMP_W-1:0];
        if (wr_en && hit(addr, OFF_CTRL)) top_d.ctrl = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (hit(addr, OFF_LAMP))   rd_data = {{(DATA_W-LAMP_W){1'b0}}, top_q.lamp};
        if (hit(addr, OFF_KEYS))   rd_data = '0;
        if (hit(addr, OFF_SEC))    rd_data = rate_val[0];
        if (hit(addr, OFF_CENTI))  rd_data = rate_val[1];
        if (hit(addr, OFF_EVENTS)) rd_data = count;
        if (hit(addr, OFF_RELOAD)) rd_data = reload;
        if (hit(addr, OFF_PRESC))  rd_data = live;
        if (hit(addr, OFF_CTRL))   rd_data = top_q.ctrl;
    end

    assign led = top_q.lamp;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        led,
    input logic              ps_tick,
    input logic [DATA_W-1:0] reload,
    input logic [DATA_W-1:0] live,
    input logic [DATA_W-1:0] count
);
    import sysctl_pkg::*;

    logic wr_live, wr_count;
    assign wr_live  = wr_en && (addr == ADDR_W'(OFF_PRESC));
    assign wr_count = wr_en && (addr == ADDR_W'(OFF_EVENTS));

    AST_LAMP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr == ADDR_W'(OFF_LAMP)) |=> led == $past(wr_data[1:0])); // R2

    AST_LAMP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFF_LAMP)) |-> rd_data[DATA_W-1:2] == '0); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !holds_state(int'(addr)) |-> rd_data == '0); // R4

    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_tick && !wr_live |=> $stable(live)); // R5

    AST_LIVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ps_tick && (live != '0) && !wr_live |=> live == $past(live) - 1'b1); // R5

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ps_tick && (live == '0) && !wr_live |=> live == $past(reload)); // R6

    AST_WRAP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ps_tick && (live == '0) && !wr_count |=> count == $past(count) + 1'b1); // R6

    AST_COUNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> count == $past(wr_data)); // R9

    AST_LIVE_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_live |=> live == $past(wr_data)); // R9
endmodule

bind sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .led     (led),
    .ps_tick (ps_tick),
    .reload  (reload),
    .live    (live),
    .count   (count)
);

// File: tb/sim_sysctl_regs.sv
`timescale 1ns/1ps
module sim_sysctl_regs;
    localparam int unsigned CLK_HZ = 1200;
    localparam int unsigned PS_HZ  = 400;
    localparam int unsigned PDIV   = CLK_HZ / PS_HZ;
    localparam int unsigned D1     = CLK_HZ;
    localparam int unsigned D100   = CLK_HZ / 100;

    localparam logic [11:0] A_LAMP = 12'h000, A_KEYS = 12'h008, A_SEC = 12'h010,
                            A_CENTI = 12'h014, A_EVT = 12'h018, A_RLD = 12'h01C,
                            A_LIVE = 12'h020, A_CTRL = 12'h04C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [1:0]  led;

    sysctl_regs #(.CLK_HZ(CLK_HZ), .PS_HZ(PS_HZ), .ADDR_W(12), .DATA_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .led(led)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";

    // behavioural reference state
    logic [31:0] m_lamp, m_ctrl, m_rld, m_live, m_evt, m_sec, m_centi;
    int unsigned pc, ph1, ph100;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lamp = 0; m_ctrl = 0; m_rld = 0; m_live = 0; m_evt = 0;
            m_sec = 0; m_centi = 0; pc = 0; ph1 = 0; ph100 = 0;
        end else begin
            bit          t;
            logic [31:0] n_live, n_evt;
            t = (pc == PDIV - 1);
            pc = t ? 0 : pc + 1;
            n_live = m_live;
            n_evt  = m_evt;
            if (t) begin
                if (m_live == 0) begin
                    n_live = m_rld;
                    n_evt  = m_evt + 1;
                end else begin
                    n_live = m_live - 1;
                end
            end
            if (ph1 == D1 - 1) begin ph1 = 0; m_sec = m_sec + 1; end
            else ph1 = ph1 + 1;
            if (ph100 == D100 - 1) begin ph100 = 0; m_centi = m_centi + 1; end
            else ph100 = ph100 + 1;
            if (wr_en) begin
                case (addr)
                    A_LAMP:  m_lamp = {30'b0, wr_data[1:0]};
                    A_CTRL:  m_ctrl = wr_data;
                    A_RLD:   m_rld = wr_data;
                    A_LIVE:  n_live = wr_data;
                    A_EVT:   n_evt = wr_data;
                    A_SEC:   begin m_sec = wr_data; ph1 = 0; end
                    A_CENTI: begin m_centi = wr_data; ph100 = 0; end
                    default: ;
                endcase
            end
            m_live = n_live;
            m_evt  = n_evt;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            A_LAMP:  return m_lamp;
            A_SEC:   return m_sec;
            A_CENTI: return m_centi;
            A_EVT:   return m_evt;
            A_RLD:   return m_rld;
            A_LIVE:  return m_live;
            A_CTRL:  return m_ctrl;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check_now();
        logic [31:0] e;
        e = exp_rd(addr);
        checks++;
        if (rd_data !== e) begin
            errors++;
            $display("FAIL %s addr=%h rd_data=%h expected=%h", cur_tag, addr, rd_data, e);
        end
        checks++;
        if (led !== m_lamp[1:0]) begin
            errors++;
            $display("FAIL %s led=%b expected=%b", cur_tag, led, m_lamp[1:0]);
        end
    endtask

    task automatic step(input logic [11:0] a, input logic we, input logic [31:0] d);
        @(negedge clk);
        if (rst_n) check_now();
        addr = a; wr_en = we; wr_data = d;
    endtask

    task automatic rd(input logic [11:0] a, input int n);
        for (int i = 0; i < n; i++) step(a, 1'b0, 32'h0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(a, 1'b1, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired during %s", cur_tag);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] all_a [10];
        all_a = '{A_LAMP, A_KEYS, A_SEC, A_CENTI, A_EVT, A_RLD, A_LIVE, A_CTRL,
                  12'h024, 12'h004};

        // R1: reset state of every word
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            addr = all_a[i];
            #1 check_now();
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: lamp bits only
        cur_tag = "R2";
        wr(A_LAMP, 32'hFFFF_FFFE); rd(A_LAMP, 3);
        wr(A_LAMP, 32'h0000_0001); rd(A_LAMP, 2);

        // R3: control word
        cur_tag = "R3";
        wr(A_CTRL, 32'hA5A5_5A5A); rd(A_CTRL, 2);
        wr(A_CTRL, 32'h0123_4567); rd(A_CTRL, 2);

        // R4: button and unmapped reads, ignored writes
        cur_tag = "R4";
        wr(12'h004, 32'hDEAD_BEEF); wr(12'h040, 32'h1111_1111);
        wr(12'h04E, 32'h2222_2222); wr(A_KEYS, 32'hFFFF_FFFF);
        rd(A_KEYS, 2); rd(12'h004, 2); rd(12'h024, 2); rd(12'h04E, 2);
        rd(A_CTRL, 2); rd(A_LAMP, 2);

        // R5 / R6: reload 5 from a start of 7
        cur_tag = "R5";
        wr(A_RLD, 32'd5); wr(A_LIVE, 32'd7); rd(A_LIVE, 30);
        cur_tag = "R6";
        wr(A_EVT, 32'd0); rd(A_EVT, 30); rd(A_LIVE, 12);

        // R7: zero reload pins prescaler, counter every tick
        cur_tag = "R7";
        wr(A_RLD, 32'd0); wr(A_LIVE, 32'd2); rd(A_LIVE, 15); rd(A_EVT, 20);

        // R8: reload write sweeps across the wrap
        cur_tag = "R8";
        for (int k = 0; k < 2 * PDIV; k++) begin
            wr(A_RLD, 32'd4); wr(A_LIVE, 32'd0);
            rd(A_LIVE, k);
            wr(A_RLD, 32'd20 + k);
            rd(A_LIVE, 8); rd(A_EVT, 2);
        end

        // R9: counter / prescaler writes swept across tick phases
        cur_tag = "R9";
        for (int k = 0; k < 2 * PDIV; k++) begin
            wr(A_RLD, 32'd3); wr(A_LIVE, 32'd0);
            rd(A_LIVE, k);
            wr(A_EVT, 32'd100 + k); rd(A_EVT, 3); rd(A_LIVE, 2);
            wr(A_LIVE, 32'd1);
            rd(A_LIVE, k);
            wr(A_LIVE, 32'd9); rd(A_LIVE, 4); rd(A_EVT, 2);
        end

        // R10: seconds counters at their rates
        cur_tag = "R10";
        rd(A_CENTI, 40); rd(A_SEC, 2);

        // R11: load restarts the period
        cur_tag = "R11";
        for (int k = 0; k < 3; k++) begin
            rd(A_CENTI, k + 4);
            wr(A_CENTI, 32'd50 + k); rd(A_CENTI, 26);
        end
        wr(A_SEC, 32'd7); rd(A_SEC, D1 + 20);
        cur_tag = "R10";
        rd(A_SEC, D1 + 10);

        // mixed reads across all words
        cur_tag = "R4";
        for (int i = 0; i < 300; i++) step(all_a[i % 10], 1'b0, 32'h0);
        step(A_LAMP, 1'b0, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule